// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This controller resolves read-after-write dependencies in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). A value computed by the ALU exists only after execute, but a dependent instruction needs it at the start of its own execute cycle. For each ALU operand, the controller compares the source register number of the instruction in execute with the destination numbers held in the execute/memory and memory/writeback pipeline registers. From that comparison it drives a two-bit select for that operand's multiplexer.

A loaded value does not exist until the end of the memory stage, so bypassing cannot rescue an instruction that directly follows a load and reads its target. The controller detects this pairing while the consumer is still in decode. For exactly one cycle it freezes the program counter and the fetch/decode register, and it requests that a bubble enter the decode/execute register. A small two-state machine records that a bubble now occupies execute. For that cycle it forces every operand select to the register-file path and blocks a new interlock, so the bubble's stale fields cannot cause a bypass or a stall. The register file writes in the first half of a cycle and reads in the second half, so writeback needs no path back to decode.

The machine has two states. FLOW is normal issue. BUBBLE is the one cycle after an interlock. FLOW goes to BUBBLE when a load-use hazard is seen. BUBBLE always returns to FLOW on the next clock. Reset enters FLOW.

Top module: `raw_hazard_unit`

## Requirements
- R1: Each operand select takes code 2'b10 (take the execute/memory result) when its source equals the execute/memory destination with that stage's write enable high. Otherwise it takes 2'b01 (take the memory/writeback result) when its source equals the memory/writeback destination with write enable high. Otherwise it is 2'b00 (register file). Code 2'b11 never appears.
- R2: When the execute/memory and memory/writeback stages both match the same source, the select is 2'b10, so the younger producer wins.
- R3: A destination of register 0, or a producer whose write enable is low, never causes a bypass or an interlock.
- R4: In FLOW, the controller asserts hold_front and bubble_req in the same cycle when the instruction in execute has its memory-read flag set, its write enable high and a nonzero destination, and that destination equals either decode source. hold_front always equals bubble_req.
- R5: An interlock lasts one cycle. In the cycle after it (state BUBBLE), hold_front and bubble_req are low and every select is 2'b00, whatever the execute-stage inputs are.
- R6: A non-load producer in execute, or a load whose destination matches no decode source, causes no interlock.
- R7: After reset the controller is in FLOW, and with all inputs zero every output is zero.
- R8: In a program where one add writes r1 and the four following instructions read it, every consumer sees the correct r1 value and no interlock occurs. A load of r1 followed at once by a reader of r1 costs exactly one bubble, and the reader still gets the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_src | input | NUM_SRC x REG_AW | Source register numbers of the instruction in decode |
| ex_src | input | NUM_SRC x REG_AW | Source register numbers of the instruction in execute |
| ex_rd | input | REG_AW | Destination of the instruction in execute |
| ex_we | input | 1 | Register write enable of the instruction in execute |
| ex_memrd | input | 1 | Memory-read (load) flag of the instruction in execute |
| mem_rd | input | REG_AW | Destination held in the execute/memory register |
| mem_we | input | 1 | Write enable held in the execute/memory register |
| wb_rd | input | REG_AW | Destination held in the memory/writeback register |
| wb_we | input | 1 | Write enable held in the memory/writeback register |
| fwd_sel | output | NUM_SRC x 2 | Per-operand select: 00 register file, 01 writeback, 10 memory stage |
| hold_front | output | 1 | Freeze the program counter and fetch/decode register |
| bubble_req | output | 1 | Zero the control fields entering decode/execute |

## Verification
A select that is stuck, swapped or has the wrong priority hands the ALU a stale operand in the same cycle. That error shows up as a wrong result in the bench's data check within two cycles. If the state machine stays in BUBBLE or skips it, the interlock repeats or the bypass is suppressed in the next cycle, and the bubble count goes wrong. A detector that misses a load-use pair lets the consumer read the pre-load register value one cycle later. A detector that fires spuriously adds a bubble to a sequence that should have run with none.

// File: rtl/rhu_pkg.sv
package rhu_pkg;

    // Operand multiplexer select encoding
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } opnd_src_e;

    // Interlock state machine
    typedef enum logic {
        ST_FLOW   = 1'b0,
        ST_BUBBLE = 1'b1
    } ilk_state_e;

endpackage

// File: rtl/bypass_pick.sv
module bypass_pick
    import rhu_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output opnd_src_e         pick
);

    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
        if (mem_hit) begin
            pick = SRC_MEM;
        end else if (wb_hit) begin
            pick = SRC_WB;
        end else begin
            pick = SRC_RF;
        end
    end

endmodule

// File: rtl/loaduse_detect.sv
module loaduse_detect #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
    input  logic [REG_AW-1:0]              ex_rd,
    input  logic                           ex_we,
    input  logic                           ex_memrd,
    output logic                           hazard
);

    logic [NUM_SRC-1:0] src_hit;
    logic               producer_ok;

    assign producer_ok = ex_memrd && ex_we && (ex_rd != '0);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_cmp
        assign src_hit[k] = (id_src[k] == ex_rd);
    end

    assign hazard = producer_ok && (|src_hit);

endmodule

// File: rtl/interlock_fsm.sv
module interlock_fsm
    import rhu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic hold_front,
    output logic bubble_req,
    output logic fwd_enable
);

    ilk_state_e state_q;
    ilk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        hold_front = 1'b0;
        bubble_req = 1'b0;
        fwd_enable = 1'b1;
        unique case (state_q)
            ST_FLOW: begin
                if (hazard) begin
                    hold_front = 1'b1;
                    bubble_req = 1'b1;
                    state_d    = ST_BUBBLE;
                end
            end
            ST_BUBBLE: begin
                fwd_enable = 1'b0;
                state_d    = ST_FLOW;
            end
        endcase
    end

endmodule

// File: rtl/raw_hazard_unit.sv
module raw_hazard_unit
    import rhu_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] ex_src,
    input  logic [REG_AW-1:0]              ex_rd,
    input  logic                           ex_we,
    input  logic                           ex_memrd,
    input  logic [REG_AW-1:0]              mem_rd,
    input  logic                           mem_we,
    input  logic [REG_AW-1:0]              wb_rd,
    input  logic                           wb_we,
    output logic [NUM_SRC-1:0][1:0]        fwd_sel,
    output logic                           hold_front,
    output logic                           bubble_req
);

    logic hazard;
    logic fwd_enable;

    loaduse_detect #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC)
    ) u_detect (
        .id_src   (id_src),
        .ex_rd    (ex_rd),
        .ex_we    (ex_we),
        .ex_memrd (ex_memrd),
        .hazard   (hazard)
    );

    interlock_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hazard     (hazard),
        .hold_front (hold_front),
        .bubble_req (bubble_req),
        .fwd_enable (fwd_enable)
    );

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
        opnd_src_e pick;

        bypass_pick #(
            .REG_AW (REG_AW)
        ) u_pick (
            .src    (ex_src[k]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .pick   (pick)
        );

        assign fwd_sel[k] = fwd_enable ? pick : SRC_RF;
    end

endmodule

// File: rtl/raw_hazard_chk.sv
module raw_hazard_chk #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
    input logic [NUM_SRC-1:0][REG_AW-1:0] ex_src,
    input logic [REG_AW-1:0]              ex_rd,
    input logic                           ex_we,
    input logic                           ex_memrd,
    input logic [REG_AW-1:0]              mem_rd,
    input logic                           mem_we,
    input logic [REG_AW-1:0]              wb_rd,
    input logic                           wb_we,
    input logic [NUM_SRC-1:0][1:0]        fwd_sel,
    input logic                           hold_front,
    input logic                           bubble_req
);

    logic prev_bub;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_bub <= 1'b0;
        else        prev_bub <= bubble_req;
    end

    // R4
    hold_eq_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_front == bubble_req);

    // R5
    single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_req |=> !bubble_req);

    // R5
    bubble_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_req |=> (fwd_sel == '0));

    // R6
    no_spurious_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_req |-> (ex_memrd && ex_we && (ex_rd != '0)));

    // R3
    zero_dest_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd == '0) && (wb_rd == '0)) |-> (fwd_sel == '0));

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd_chk
        // R1
        legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_sel[k] != 2'b11);

        // R2
        mem_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!prev_bub && mem_we && (mem_rd != '0) && (ex_src[k] == mem_rd))
            |-> (fwd_sel[k] == 2'b10));

        // R4
        load_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!prev_bub && ex_memrd && ex_we && (ex_rd != '0) && (id_src[k] == ex_rd))
            |-> bubble_req);
    end

endmodule

bind raw_hazard_unit raw_hazard_chk #(
    .REG_AW  (REG_AW),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_src     (id_src),
    .ex_src     (ex_src),
    .ex_rd      (ex_rd),
    .ex_we      (ex_we),
    .ex_memrd   (ex_memrd),
    .mem_rd     (mem_rd),
    .mem_we     (mem_we),
    .wb_rd      (wb_rd),
    .wb_we      (wb_we),
    .fwd_sel    (fwd_sel),
    .hold_front (hold_front),
    .bubble_req (bubble_req)
);

// File: tb/raw_hazard_unit_bench.sv
`timescale 1ns/1ps
module raw_hazard_unit_bench;

    localparam int NPROG  = 22;
    localparam int OP_ALU = 0;
    localparam int OP_LD  = 1;
    localparam int OP_NOP = 2;
    localparam int OP_ST  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0][4:0] id_src = '0;
    logic [1:0][4:0] ex_src = '0;
    logic [4:0] ex_rd = '0;
    logic ex_we = 1'b0;
    logic ex_memrd = 1'b0;
    logic [4:0] mem_rd = '0;
    logic mem_we = 1'b0;
    logic [4:0] wb_rd = '0;
    logic wb_we = 1'b0;
    logic [1:0][1:0] fwd_sel;
    logic hold_front;
    logic bubble_req;

    always #2 clk = ~clk;

    raw_hazard_unit u_raw_hazard_unit (
        .clk(clk), .rst_n(rst_n), .id_src(id_src), .ex_src(ex_src),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_memrd(ex_memrd),
        .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_sel(fwd_sel), .hold_front(hold_front), .bubble_req(bubble_req)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int p_op [NPROG];
    int p_rd [NPROG];
    int p_s1 [NPROG];
    int p_s2 [NPROG];
    logic [31:0] p_ld [NPROG];
    logic [31:0] gold_a [NPROG];
    logic [31:0] gold_b [NPROG];

    logic [31:0] rf [32];
    int ifid, idex, exmem, memwb, pc;
    logic [31:0] exmem_val, memwb_val;
    bit prev_bub;
    int bubbles;
    int bubbles_before_load = -1;

    function automatic bit writes(int i);
        return (i >= 0) && (p_op[i] == OP_ALU || p_op[i] == OP_LD);
    endfunction

    function automatic int dst(int i);
        return (i >= 0) ? p_rd[i] : 0;
    endfunction

    task automatic put(int i, int op, int rd, int s1, int s2, logic [31:0] ld);
        p_op[i] = op; p_rd[i] = rd; p_s1[i] = s1; p_s2[i] = s2; p_ld[i] = ld;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_sel(int s);
        if (prev_bub) return 0;
        if (writes(exmem) && dst(exmem) != 0 && dst(exmem) == s) return 2;
        if (writes(memwb) && dst(memwb) != 0 && dst(memwb) == s) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(int s);
        if (prev_bub) return "R5";
        if (s == 0) return "R3";
        if ((exmem >= 0 && dst(exmem) == s && !writes(exmem)) ||
            (memwb >= 0 && dst(memwb) == s && !writes(memwb))) return "R3";
        if (dst(exmem) == s && dst(memwb) == s && writes(exmem) && writes(memwb)) return "R2";
        return "R1";
    endfunction

    task automatic step();
        bit exp_stall;
        int srcs [2];
        logic [31:0] opv [2];
        logic [31:0] res;
        @(negedge clk);
        id_src[0] = (ifid >= 0) ? 5'(p_s1[ifid]) : '0;
        id_src[1] = (ifid >= 0) ? 5'(p_s2[ifid]) : '0;
        srcs[0]   = (idex >= 0) ? p_s1[idex] : 0;
        srcs[1]   = (idex >= 0) ? p_s2[idex] : 0;
        ex_src[0] = 5'(srcs[0]);
        ex_src[1] = 5'(srcs[1]);
        ex_rd     = 5'(dst(idex));
        ex_we     = writes(idex);
        ex_memrd  = (idex >= 0) && (p_op[idex] == OP_LD);
        mem_rd    = 5'(dst(exmem));
        mem_we    = writes(exmem);
        wb_rd     = 5'(dst(memwb));
        wb_we     = writes(memwb);
        #1;
        exp_stall = !prev_bub && ex_memrd && (dst(idex) != 0) && (ifid >= 0) &&
                    (p_s1[ifid] == dst(idex) || p_s2[ifid] == dst(idex));
        if (exp_stall) begin
            check("R4", "bubble_req", int'(bubble_req), 1);
            check("R4", "hold_front", int'(hold_front), 1);
        end else if (prev_bub) begin
            check("R5", "bubble_req", int'(bubble_req), 0);
            check("R5", "hold_front", int'(hold_front), 0);
        end else begin
            check("R6", "bubble_req", int'(bubble_req), 0);
            check("R6", "hold_front", int'(hold_front), 0);
        end
        for (int k = 0; k < 2; k++) begin
            check(sel_tag(srcs[k]), $sformatf("fwd_sel[%0d]", k), int'(fwd_sel[k]), exp_sel(srcs[k]));
            if (fwd_sel[k] == 2'b10)      opv[k] = exmem_val;
            else if (fwd_sel[k] == 2'b01) opv[k] = memwb_val;
            else if (writes(memwb) && dst(memwb) != 0 && dst(memwb) == srcs[k]) opv[k] = memwb_val;
            else                          opv[k] = rf[srcs[k]];
        end
        res = '0;
        if (idex >= 0 && p_op[idex] != OP_NOP) begin
            // R8: operand values reaching execute
            check("R8", $sformatf("instr %0d operand a", idex), int'(opv[0]), int'(gold_a[idex]));
            check("R8", $sformatf("instr %0d operand b", idex), int'(opv[1]), int'(gold_b[idex]));
            if (p_op[idex] == OP_LD)       res = p_ld[idex];
            else if (p_op[idex] == OP_ALU) res = opv[0] + opv[1];
        end
        if (idex == 5 && bubbles_before_load < 0) bubbles_before_load = bubbles;
        @(posedge clk);
        if (writes(memwb) && dst(memwb) != 0) rf[dst(memwb)] = memwb_val;
        memwb = exmem; memwb_val = exmem_val;
        exmem = idex;  exmem_val = res;
        if (exp_stall) begin
            idex = -1;
            bubbles++;
        end else begin
            idex = ifid;
            ifid = (pc < NPROG) ? pc : -1;
            pc++;
        end
        prev_bub = exp_stall;
    endtask

    initial begin
        logic [31:0] arch [32];
        int pairs;
        put(0,  OP_ALU, 1, 2, 3, 0);
        put(1,  OP_ALU, 4, 1, 3, 0);
        put(2,  OP_ALU, 6, 1, 7, 0);
        put(3,  OP_ALU, 8, 1, 9, 0);
        put(4,  OP_ALU, 10, 1, 11, 0);
        put(5,  OP_LD,  1, 2, 0, 32'h1111);
        put(6,  OP_ALU, 4, 1, 6, 0);
        put(7,  OP_ALU, 12, 1, 4, 0);
        put(8,  OP_ALU, 0, 2, 3, 0);
        put(9,  OP_ALU, 13, 0, 0, 0);
        put(10, OP_ST,  5, 2, 3, 0);
        put(11, OP_ALU, 14, 5, 5, 0);
        put(12, OP_ALU, 7, 1, 1, 0);
        put(13, OP_ALU, 7, 7, 2, 0);
        put(14, OP_ALU, 16, 7, 7, 0);
        put(15, OP_LD,  17, 0, 0, 32'h2222);
        put(16, OP_ALU, 18, 2, 17, 0);
        put(17, OP_LD,  19, 3, 0, 32'h3333);
        put(18, OP_NOP, 0, 0, 0, 0);
        put(19, OP_ALU, 20, 19, 19, 0);
        put(20, OP_LD,  0, 2, 0, 32'h4444);
        put(21, OP_ALU, 22, 0, 1, 0);
        for (int r = 0; r < 32; r++) begin
            rf[r]   = (r == 0) ? 32'h0 : 32'(r * 16 + 3);
            arch[r] = rf[r];
        end
        pairs = 0;
        for (int i = 0; i < NPROG; i++) begin
            logic [31:0] v;
            gold_a[i] = arch[p_s1[i]];
            gold_b[i] = arch[p_s2[i]];
            v = (p_op[i] == OP_LD) ? p_ld[i] : gold_a[i] + gold_b[i];
            if (writes(i) && p_rd[i] != 0) arch[p_rd[i]] = v;
            if (i + 1 < NPROG && p_op[i] == OP_LD && p_rd[i] != 0 &&
                (p_s1[i+1] == p_rd[i] || p_s2[i+1] == p_rd[i])) pairs++;
        end
        ifid = -1; idex = -1; exmem = -1; memwb = -1; pc = 0;
        exmem_val = '0; memwb_val = '0; prev_bub = 0; bubbles = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state with zero inputs
        check("R7", "fwd_sel in reset", int'(fwd_sel), 0);
        check("R7", "bubble_req in reset", int'(bubble_req), 0);
        check("R7", "hold_front in reset", int'(hold_front), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R7", "fwd_sel after reset", int'(fwd_sel), 0);
        check("R7", "bubble_req after reset", int'(bubble_req), 0);
        ifid = 0; pc = 1;
        for (int c = 0; c < NPROG + 12; c++) step();
        // R8: forwarding chain costs nothing, each load-use pair one bubble
        check("R8", "bubbles before first load", bubbles_before_load, 0);
        check("R8", "total bubbles", bubbles, pairs);
        check("R8", "load-use pairs in program", pairs, 2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule